// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits next to the ECC decoder of a DRAM controller and records the error events that the decoder reports. Each clock cycle the decoder may raise a correctable-error pulse, an uncorrectable-error pulse, or both, each with the failing address. The block counts the two kinds separately and keeps the address of the most recent correctable error and of the first uncorrectable one. While an enabled error class is pending it holds an active-high level interrupt.

Software reaches the block through a simple 32-bit register bus. Reads are combinational on the byte address and are never blocked. Writes to any register other than the key register take effect only while the block is unlocked. Writing the unlock key opens the block and writing any other value to the key register closes it again. A configuration register carries the ECC-enable and DRAM-type bits and drives them out to the controller. A clear bit in the control/status register wipes the counters, the pending flags and the first-error capture while it stays set.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the block is locked, every register reads 0, both configuration outputs are 0 and the interrupt is low.
- R2: Writing 0xFC600309 to offset 0x00 unlocks writes and writing any other value there locks them. A write to offset 0x04 or 0x50 while locked changes nothing. Offset 0x00 always reads 0, reads are never blocked, and an unmapped offset reads 0.
- R3: Configuration register 0x04: bit 7 is ECC enable (output `cfg_ecc_en`) and bit 4 selects the DRAM type, 1 for DDR4 and 0 for DDR3 (output `cfg_ddr4`). All other bits read 0.
- R4: Control/status register 0x50: bits 23:16 count correctable-error pulses and bits 15:12 count uncorrectable-error pulses. Each pulse adds one from the following cycle on, and software writes to these bits have no effect.
- R5: The correctable counter saturates at 255 and the uncorrectable counter at 15. Neither wraps.
- R6: Offset 0x5C holds the address of the most recent correctable error and is overwritten by every correctable pulse.
- R7: Offset 0x58 captures the address of the first uncorrectable error after reset or after a clear. Later uncorrectable pulses leave it unchanged.
- R8: While bit 31 of 0x50 reads 1, both counters and both pending flags are held at 0, the first-error capture is re-armed, and error pulses are neither counted nor captured. Bit 31 stays set until software writes it back to 0.
- R9: Bits 0 and 1 of 0x50 enable the correctable and uncorrectable interrupt sources. Bits 2 and 3 are the sticky correctable and uncorrectable pending flags, set by a counted pulse and cleared only by R8. The output `irq` is (bit0 AND bit2) OR (bit1 AND bit3).
- R10: A correctable and an uncorrectable pulse in the same cycle are both counted and both addresses are captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current bus address |
| bus_addr | input | BUS_AW (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ce_pulse | input | 1 | Correctable error seen this cycle |
| ce_addr | input | ERR_AW (32) | Address of the correctable error |
| ue_pulse | input | 1 | Uncorrectable error seen this cycle |
| ue_addr | input | ERR_AW (32) | Address of the uncorrectable error |
| cfg_ecc_en | output | 1 | ECC enable configuration bit |
| cfg_ddr4 | output | 1 | DRAM type bit, 1 = DDR4 |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the block with its default parameters: 32-bit error addresses, an 8-bit correctable counter and a 4-bit uncorrectable counter. With these widths both saturation points can be reached in a few hundred pulses, so the bench drives counters into saturation directly. It also shows that the 4-bit counter reaches its limit long before the 8-bit one. The random phase mixes key writes (half of them the right key), configuration and control writes with random clear bits, and error pulses on either or both inputs. This places locks, clears and simultaneous events over counters that sit at zero, at intermediate values and at their limits.

// File: rtl/ecc_err_log_pkg.sv
`timescale 1ns/1ps
package ecc_err_log_pkg;

   // register byte offsets (software visible)
   localparam int unsigned OFS_KEY     = 'h00;
   localparam int unsigned OFS_CFG     = 'h04;
   localparam int unsigned OFS_CTRL    = 'h50;
   localparam int unsigned OFS_UE_ADDR = 'h58;
   localparam int unsigned OFS_CE_ADDR = 'h5C;

   localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

   // configuration field positions
   localparam int unsigned CFG_ECC_BIT  = 7;
   localparam int unsigned CFG_DDR4_BIT = 4;

   // control/status field positions
   localparam int unsigned CTRL_CLR_BIT  = 31;
   localparam int unsigned CTRL_CE_LSB   = 16;
   localparam int unsigned CTRL_CE_FIELD = 8;
   localparam int unsigned CTRL_UE_LSB   = 12;
   localparam int unsigned CTRL_UE_FIELD = 4;
   localparam int unsigned CTRL_CE_EN    = 0;
   localparam int unsigned CTRL_UE_EN    = 1;
   localparam int unsigned CTRL_CE_PEND  = 2;
   localparam int unsigned CTRL_UE_PEND  = 3;

   typedef enum logic {
      CAP_FIRST = 1'b0,
      CAP_LAST  = 1'b1
   } cap_policy_e;

   typedef struct packed {
      logic ecc_en;
      logic ddr4;
   } cfg_t;

   typedef struct packed {
      logic clr;
      logic ue_en;
      logic ce_en;
   } ctrl_t;

endpackage

// File: rtl/ecc_key_lock.sv
`timescale 1ns/1ps
module ecc_key_lock #(
   parameter int unsigned  DW  = 32,
   parameter logic [DW-1:0] KEY = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          key_wr,
   input  logic [DW-1:0] wdata,
   output logic          unlocked
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
      end else if (key_wr) begin
         unlocked <= (wdata == KEY);
      end
   end

endmodule

// File: rtl/ecc_sat_counter.sv
`timescale 1ns/1ps
module ecc_sat_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count,
   output logic         seen
);

   localparam logic [W-1:0] CMAX = '1;
   localparam logic [W-1:0] ONE  = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         seen  <= 1'b0;
      end else if (clr) begin
         count <= '0;
         seen  <= 1'b0;
      end else if (inc) begin
         seen <= 1'b1;
         if (count != CMAX) begin
            count <= count + ONE;
         end
      end
   end

endmodule

// File: rtl/ecc_addr_capture.sv
`timescale 1ns/1ps
module ecc_addr_capture
   import ecc_err_log_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter cap_policy_e POLICY = CAP_LAST
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hit,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_q,
   output logic          held
);

   logic take;

   generate
      if (POLICY == CAP_FIRST) begin : g_first
         assign take = hit && !clr && !held;
      end else begin : g_last
         assign take = hit && !clr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (take) begin
         addr_q <= addr_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= 1'b0;
      end else if (clr) begin
         held <= 1'b0;
      end else if (hit) begin
         held <= 1'b1;
      end
   end

endmodule

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
module ecc_err_log
   import ecc_err_log_pkg::*;
#(
   parameter int unsigned ERR_AW   = 32,
   parameter int unsigned CE_CNT_W = 8,
   parameter int unsigned UE_CNT_W = 4,
   parameter int unsigned BUS_AW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ce_pulse,
   input  logic [ERR_AW-1:0] ce_addr,
   input  logic              ue_pulse,
   input  logic [ERR_AW-1:0] ue_addr,
   output logic              cfg_ecc_en,
   output logic              cfg_ddr4,
   output logic              irq
);

   localparam logic [BUS_AW-1:0] A_KEY  = BUS_AW'(OFS_KEY);
   localparam logic [BUS_AW-1:0] A_CFG  = BUS_AW'(OFS_CFG);
   localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
   localparam logic [BUS_AW-1:0] A_UEA  = BUS_AW'(OFS_UE_ADDR);
   localparam logic [BUS_AW-1:0] A_CEA  = BUS_AW'(OFS_CE_ADDR);

   // elaboration-time parameter checks
   generate
      if (CE_CNT_W < 1 || CE_CNT_W > CTRL_CE_FIELD) begin : g_bad_ce_w
         $error("CE_CNT_W must lie in 1..%0d", CTRL_CE_FIELD);
      end
      if (UE_CNT_W < 1 || UE_CNT_W > CTRL_UE_FIELD) begin : g_bad_ue_w
         $error("UE_CNT_W must lie in 1..%0d", CTRL_UE_FIELD);
      end
      if (ERR_AW < 1 || ERR_AW > 32) begin : g_bad_err_aw
         $error("ERR_AW must lie in 1..32");
      end
      if (BUS_AW < 7 || BUS_AW > 32) begin : g_bad_bus_aw
         $error("BUS_AW must lie in 7..32");
      end
   endgenerate

   // write protection
   logic lock_open;
   logic key_wr;

   assign key_wr = bus_we && (bus_addr == A_KEY);

   ecc_key_lock #(
      .DW  (32),
      .KEY (UNLOCK_KEY)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (key_wr),
      .wdata    (bus_wdata),
      .unlocked (lock_open)
   );

   logic cfg_wr;
   logic ctrl_wr;

   assign cfg_wr  = bus_we && lock_open && (bus_addr == A_CFG);
   assign ctrl_wr = bus_we && lock_open && (bus_addr == A_CTRL);

   // configuration register
   cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_wr) begin
         cfg_q.ecc_en <= bus_wdata[CFG_ECC_BIT];
         cfg_q.ddr4   <= bus_wdata[CFG_DDR4_BIT];
      end
   end

   assign cfg_ecc_en = cfg_q.ecc_en;
   assign cfg_ddr4   = cfg_q.ddr4;

   // control bits
   ctrl_t ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.clr   <= bus_wdata[CTRL_CLR_BIT];
         ctrl_q.ue_en <= bus_wdata[CTRL_UE_EN];
         ctrl_q.ce_en <= bus_wdata[CTRL_CE_EN];
      end
   end

   logic clr_q;
   assign clr_q = ctrl_q.clr;

   // error counters
   logic [CE_CNT_W-1:0] ce_cnt;
   logic [UE_CNT_W-1:0] ue_cnt;
   logic                ce_pend;
   logic                ue_pend;

   ecc_sat_counter #(.W(CE_CNT_W)) u_ce_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_q),
      .inc   (ce_pulse),
      .count (ce_cnt),
      .seen  (ce_pend)
   );

   ecc_sat_counter #(.W(UE_CNT_W)) u_ue_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_q),
      .inc   (ue_pulse),
      .count (ue_cnt),
      .seen  (ue_pend)
   );

   // address capture
   logic [ERR_AW-1:0] ce_addr_q;
   logic [ERR_AW-1:0] ue_addr_q;
   logic              ce_held;
   logic              ue_held;

   ecc_addr_capture #(
      .AW     (ERR_AW),
      .POLICY (CAP_LAST)
   ) u_ce_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_q),
      .hit     (ce_pulse),
      .addr_in (ce_addr),
      .addr_q  (ce_addr_q),
      .held    (ce_held)
   );

   ecc_addr_capture #(
      .AW     (ERR_AW),
      .POLICY (CAP_FIRST)
   ) u_ue_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_q),
      .hit     (ue_pulse),
      .addr_in (ue_addr),
      .addr_q  (ue_addr_q),
      .held    (ue_held)
   );

   // interrupt
   assign irq = (ctrl_q.ce_en && ce_pend) || (ctrl_q.ue_en && ue_pend);

   // read path
   logic [31:0] cfg_rd;
   logic [31:0] ctrl_rd;

   always_comb begin
      cfg_rd               = '0;
      cfg_rd[CFG_ECC_BIT]  = cfg_q.ecc_en;
      cfg_rd[CFG_DDR4_BIT] = cfg_q.ddr4;
   end

   always_comb begin
      ctrl_rd                           = '0;
      ctrl_rd[CTRL_CLR_BIT]             = ctrl_q.clr;
      ctrl_rd[CTRL_CE_LSB +: CE_CNT_W]  = ce_cnt;
      ctrl_rd[CTRL_UE_LSB +: UE_CNT_W]  = ue_cnt;
      ctrl_rd[CTRL_UE_PEND]             = ue_pend;
      ctrl_rd[CTRL_CE_PEND]             = ce_pend;
      ctrl_rd[CTRL_UE_EN]               = ctrl_q.ue_en;
      ctrl_rd[CTRL_CE_EN]               = ctrl_q.ce_en;
   end

   always_comb begin
      case (bus_addr)
         A_CFG:   bus_rdata = cfg_rd;
         A_CTRL:  bus_rdata = ctrl_rd;
         A_UEA:   bus_rdata = 32'(ue_addr_q);
         A_CEA:   bus_rdata = 32'(ce_addr_q);
         default: bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ecc_err_log_chk.sv
`timescale 1ns/1ps
module ecc_err_log_chk
   import ecc_err_log_pkg::*;
#(
   parameter int unsigned ERR_AW   = 32,
   parameter int unsigned CE_CNT_W = 8,
   parameter int unsigned UE_CNT_W = 4,
   parameter int unsigned BUS_AW   = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [BUS_AW-1:0]   bus_addr,
   input logic                unlocked,
   input logic                cfg_ecc_en,
   input logic                cfg_ddr4,
   input logic                clr,
   input logic [CE_CNT_W-1:0] ce_cnt,
   input logic [UE_CNT_W-1:0] ue_cnt,
   input logic                ce_pend,
   input logic                ue_pend,
   input logic                ue_held,
   input logic [ERR_AW-1:0]   ue_addr_q,
   input logic                irq
);

   localparam logic [BUS_AW-1:0] A_CFG = BUS_AW'(OFS_CFG);

   // R2: a locked configuration write leaves the outputs alone
   a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_CFG && !unlocked) |=> ($stable(cfg_ecc_en) && $stable(cfg_ddr4)));

   // R5: outside a clear the counters never go down (no wrap)
   a_r5_ce_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (ce_cnt >= $past(ce_cnt)));

   a_r5_ue_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (ue_cnt >= $past(ue_cnt)));

   // R7: once the first uncorrectable address is held it stays put
   a_r7_ue_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_held && !clr) |=> $stable(ue_addr_q));

   // R8: a set clear bit empties counters and pending flags
   a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ce_cnt == '0 && ue_cnt == '0 && !ce_pend && !ue_pend));

   // R9: no interrupt without a pending source
   a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ce_pend || ue_pend));

endmodule

bind ecc_err_log ecc_err_log_chk #(
   .ERR_AW   (ERR_AW),
   .CE_CNT_W (CE_CNT_W),
   .UE_CNT_W (UE_CNT_W),
   .BUS_AW   (BUS_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .unlocked   (lock_open),
   .cfg_ecc_en (cfg_ecc_en),
   .cfg_ddr4   (cfg_ddr4),
   .clr        (clr_q),
   .ce_cnt     (ce_cnt),
   .ue_cnt     (ue_cnt),
   .ce_pend    (ce_pend),
   .ue_pend    (ue_pend),
   .ue_held    (ue_held),
   .ue_addr_q  (ue_addr_q),
   .irq        (irq)
);

// File: tb/test_ecc_err_log.sv
`timescale 1ns/1ps
module test_ecc_err_log;

   localparam logic [7:0]  K_KEY  = 8'h00;
   localparam logic [7:0]  K_CFG  = 8'h04;
   localparam logic [7:0]  K_CTRL = 8'h50;
   localparam logic [7:0]  K_UEA  = 8'h58;
   localparam logic [7:0]  K_CEA  = 8'h5C;
   localparam logic [31:0] KEYV   = 32'hFC60_0309;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ce_pulse = 1'b0;
   logic [31:0] ce_addr = '0;
   logic        ue_pulse = 1'b0;
   logic [31:0] ue_addr = '0;
   logic        cfg_ecc_en;
   logic        cfg_ddr4;
   logic        irq;

   always #5 clk = ~clk;

   ecc_err_log i_ecc_err_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ce_pulse   (ce_pulse),
      .ce_addr    (ce_addr),
      .ue_pulse   (ue_pulse),
      .ue_addr    (ue_addr),
      .cfg_ecc_en (cfg_ecc_en),
      .cfg_ddr4   (cfg_ddr4),
      .irq        (irq)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;
   logic [31:0] last_rd;

   // reference model of the requirements
   bit          m_unl, m_ecc, m_ddr4, m_clr, m_cen, m_uen, m_cep, m_uep, m_held;
   int          m_ce, m_ue;
   logic [31:0] m_cea, m_uea;

   task automatic model_reset();
      m_unl = 0; m_ecc = 0; m_ddr4 = 0; m_clr = 0; m_cen = 0; m_uen = 0;
      m_cep = 0; m_uep = 0; m_held = 0; m_ce = 0; m_ue = 0; m_cea = 0; m_uea = 0;
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         K_CFG:  begin r[7] = m_ecc; r[4] = m_ddr4; end
         K_CTRL: begin
            r[31] = m_clr; r[23:16] = 8'(m_ce); r[15:12] = 4'(m_ue);
            r[3] = m_uep; r[2] = m_cep; r[1] = m_uen; r[0] = m_cen;
         end
         K_UEA:  r = m_uea;
         K_CEA:  r = m_cea;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_for(input logic [7:0] a);
      case (a)
         K_CFG:  return "R3";
         K_CTRL: return "R4";
         K_UEA:  return "R7";
         K_CEA:  return "R6";
         default: return "R2";
      endcase
   endfunction

   function automatic bit exp_irq();
      return (m_cen && m_cep) || (m_uen && m_uep);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // one bus/error cycle: drive, check the pre-edge state, advance the model
   task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input bit ce, input logic [31:0] cea,
                      input bit ue, input logic [31:0] uea);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d;
      ce_pulse = ce; ce_addr = cea; ue_pulse = ue; ue_addr = uea;
      #1;
      last_rd = bus_rdata;
      check(tag_for(a), bus_rdata, exp_read(a));
      check("R9", 32'(irq), 32'(exp_irq()));
      check("R3", {30'd0, cfg_ecc_en, cfg_ddr4}, {30'd0, m_ecc, m_ddr4});
      // next state from the requirements
      if (m_clr) begin
         m_ce = 0; m_ue = 0; m_cep = 0; m_uep = 0; m_held = 0;
      end else begin
         if (ce) begin
            m_cep = 1; m_cea = cea;
            if (m_ce < 255) m_ce++;
         end
         if (ue) begin
            m_uep = 1;
            if (!m_held) m_uea = uea;
            m_held = 1;
            if (m_ue < 15) m_ue++;
         end
      end
      if (we) begin
         if (a == K_KEY) m_unl = (d == KEYV);
         else if (m_unl && a == K_CFG) begin m_ecc = d[7]; m_ddr4 = d[4]; end
         else if (m_unl && a == K_CTRL) begin m_clr = d[31]; m_uen = d[1]; m_cen = d[0]; end
      end
      @(posedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1, a, d, 0, '0, 0, '0);
   endtask

   task automatic peek(input logic [7:0] a);
      cyc(0, a, '0, 0, '0, 0, '0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset state
      peek(K_KEY);  check("R1", last_rd, 32'h0);
      peek(K_CFG);  check("R1", last_rd, 32'h0);
      peek(K_CTRL); check("R1", last_rd, 32'h0);
      peek(K_UEA);  check("R1", last_rd, 32'h0);
      peek(K_CEA);  check("R1", last_rd, 32'h0);
      check("R1", {29'd0, irq, cfg_ecc_en, cfg_ddr4}, 32'h0);

      // R2: locked write ignored, unmapped offset reads 0
      wr(K_CFG, 32'hFFFF_FFFF);
      peek(K_CFG); check("R2", last_rd, 32'h0);
      peek(8'h40); check("R2", last_rd, 32'h0);

      // R3: unlock and write configuration
      wr(K_KEY, KEYV);
      wr(K_CFG, 32'hFFFF_FFFF);
      peek(K_CFG); check("R3", last_rd, 32'h0000_0090);
      check("R3", {30'd0, cfg_ecc_en, cfg_ddr4}, 32'h3);
      wr(K_CFG, 32'h0000_0080);
      peek(K_CFG); check("R3", last_rd, 32'h0000_0080);

      // R2: lock with the inverted key, write refused
      wr(K_KEY, ~KEYV);
      wr(K_CFG, 32'h0);
      peek(K_CFG); check("R2", last_rd, 32'h0000_0080);
      peek(K_KEY); check("R2", last_rd, 32'h0);

      // R4/R6/R7: counting and address policies
      wr(K_KEY, KEYV);
      wr(K_CTRL, 32'h00FF_F003);   // count fields not writable (R4)
      cyc(0, K_CTRL, '0, 1, 32'h10, 0, '0);
      cyc(0, K_CTRL, '0, 1, 32'h20, 0, '0);
      cyc(0, K_CTRL, '0, 1, 32'h30, 0, '0);
      cyc(0, K_CTRL, '0, 0, '0, 1, 32'h100);
      cyc(0, K_CTRL, '0, 0, '0, 1, 32'h200);
      cyc(0, K_CTRL, '0, 0, '0, 1, 32'h300);
      peek(K_CTRL); check("R4", last_rd, 32'h0003_300F);
      peek(K_CEA);  check("R6", last_rd, 32'h30);
      peek(K_UEA);  check("R7", last_rd, 32'h100);
      check("R9", 32'(irq), 32'h1);

      // R8: clear holds everything empty, pulses during clear lost
      wr(K_CTRL, 32'h8000_0003);
      cyc(0, K_CTRL, '0, 1, 32'h44, 1, 32'h55);
      cyc(0, K_CTRL, '0, 1, 32'h46, 1, 32'h57);
      peek(K_CTRL); check("R8", last_rd, 32'h8000_0003);
      check("R8", 32'(irq), 32'h0);
      wr(K_CTRL, 32'h0000_0003);
      peek(K_CTRL); check("R8", last_rd, 32'h0000_0003);
      peek(K_CEA);  check("R8", last_rd, 32'h30);

      // R10: simultaneous events; R7 capture re-armed after clear
      cyc(0, K_CTRL, '0, 1, 32'hAAA0, 1, 32'hBBB0);
      peek(K_CTRL); check("R10", last_rd, 32'h0001_100F);
      peek(K_CEA);  check("R10", last_rd, 32'hAAA0);
      peek(K_UEA);  check("R7", last_rd, 32'hBBB0);

      // R5: saturation
      for (int i = 0; i < 300; i++)
         cyc(0, K_CTRL, '0, 1, 32'(i), (i < 20), 32'(i));
      peek(K_CTRL);
      check("R5", 32'(last_rd[23:16]), 32'd255);
      check("R5", 32'(last_rd[15:12]), 32'd15);

      // R9: only the enabled source drives irq
      wr(K_CTRL, 32'h8000_0000);
      wr(K_CTRL, 32'h0000_0002);
      cyc(0, K_CTRL, '0, 1, 32'h1, 0, '0);
      peek(K_CTRL); check("R9", 32'(irq), 32'h0);
      cyc(0, K_CTRL, '0, 0, '0, 1, 32'h2);
      peek(K_CTRL); check("R9", 32'(irq), 32'h1);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         bit          we;
         case ($urandom_range(0, 5))
            0: a = K_KEY;
            1: a = K_CFG;
            2: a = K_CTRL;
            3: a = K_UEA;
            4: a = K_CEA;
            default: a = 8'h20;
         endcase
         we = ($urandom_range(0, 3) == 0);
         d  = $urandom();
         if (a == K_KEY && $urandom_range(0, 1) == 1) d = KEYV;
         if (a == K_CTRL) d[31] = ($urandom_range(0, 3) == 0);
         cyc(we, a, d, ($urandom_range(0, 2) == 0), $urandom(),
             ($urandom_range(0, 4) == 0), $urandom());
      end
      peek(K_CTRL);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule